// File: doc/BRIEF.md
# Banked Frequency-Hopping Sine/Cosine Oscillator

This block is a time-multiplexed numerically controlled oscillator. Each input sample names one channel. For that channel the block adds a phase step to a private accumulator and looks the phase up in a sine table. It returns a sine value and a cosine value, tagged with the channel and the bank that produced them. The phase steps are kept in a small dual-port store that is divided into several banks of preset frequencies. A bank index that comes with each sample chooses which bank feeds the accumulators. Changing that index makes every channel hop to another preset frequency. The accumulated phase stays continuous across the hop.

Software loads and reads back the step words through a simple memory-mapped agent port. Word `b*NUM_CH + c` holds the step for channel `c` of bank `b`. Each word has the accumulator width plus two inversion flags. Software must only write banks that are not currently selected. A sync flag on a sample restarts that channel: the accumulator is cleared and the phase offset is reloaded. The output frequency is `sample_rate * step / 2^ACC_W`. Each output bit buys roughly 6 dB of spur-free range.

Top module: `nco_hop_top`

## Requirements
- R1: While `rst_n` is low and on the first edges after it, `out_valid` and `reg_rvalid` are 0. Every step word, accumulator and offset reads as zero after reset.
- R2: A register access with `reg_req`=1 and `reg_write`=1 stores `reg_wdata` at word `reg_addr`. With `reg_write`=0 the word is returned on `reg_rdata`, with `reg_rvalid`=1, one cycle later. Word `b*NUM_CH+c` (4 channels, 3 banks, 12 words) is the step of channel `c` in bank `b`. Addresses 12 and above store nothing and read as 0.
- R3: Each valid sample for channel `c` uses phase `(acc[c] + off[c]) mod 2^16`. It then sets `acc[c]` to `acc[c]` plus the low 16 bits of the active bank's word. The sine-table index is the top 8 bits of that phase.
- R4: With table index `k`, `out_sin` is within 5 LSB of `round(2047*sin(2*pi*k/256))`. `out_cos` is the same function taken at `(k+64) mod 256`.
- R5: Word bit 16 negates the sine output and word bit 17 negates the cosine output of that channel.
- R6: `out_valid`, `out_ch` and `out_bank` follow a valid input exactly 4 clock edges after the edge that samples it. There is one output per input, in input order.
- R7: A change of the bank index takes effect from the next sample. The accumulator carries on from its current phase, so the output frequency hops without a phase jump.
- R8: A bank index of 3 or above is treated as bank 2 (the last bank), both for the step fetch and for `out_bank`.
- R9: A valid sample with `in_sync`=1 uses accumulator 0 and offset `in_phase` for that channel, and keeps `in_phase` as the channel's new offset. The stored step words are unchanged.
- R10: Cycles with `in_valid`=0 leave every accumulator and offset unchanged.
- R11: Channels advance independently: a sample for one channel never moves another channel's phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| in_valid | input | 1 | Produce a sample this cycle |
| in_ch | input | CH_W (2) | Channel of the sample |
| in_bank | input | BANK_W (2) | Active frequency bank |
| in_sync | input | 1 | Restart the channel phase |
| in_phase | input | ACC_W (16) | Phase offset loaded on sync |
| reg_req | input | 1 | Register access request |
| reg_write | input | 1 | 1 = write, 0 = read |
| reg_addr | input | REG_AW (4) | Step word address |
| reg_wdata | input | INC_W (18) | Write data |
| reg_rdata | output | INC_W (18) | Read data |
| reg_rvalid | output | 1 | Read data valid |
| out_valid | output | 1 | Output sample valid |
| out_ch | output | CH_W (2) | Channel of the output |
| out_bank | output | BANK_W (2) | Bank that produced the output |
| out_sin | output | OUT_W (12) | Signed sine |
| out_cos | output | OUT_W (12) | Signed cosine |

## Verification
A sample whose inputs are sampled at one rising edge shows up on the outputs after the fourth rising edge, counting that one. Read data appears after the edge that follows the read request. When the driver launches a sample, it stores the expected result together with the cycle count. The monitor samples on falling edges and checks that exactly four counted edges have passed before it compares the values. Register reads are checked on the falling edge right after the sampling edge. A reference phase model in the bench follows every hop, sync and idle gap, so each sine and cosine value is compared against the phase it should have.

// File: rtl/nco_pkg.sv
// Shared helpers for the banked oscillator.
// Assumes table sizes of at most 2^12 entries, so 64-bit intermediates never overflow.
package nco_pkg;

    // Number of clock edges from input sampling to output register.
    localparam int NCO_LATENCY = 4;

    // Integer approximation of amp*sin(2*pi*k/2^aw), rational form, error below 4 LSB.
    function automatic int sine_q(input int k, input int aw, input int amp);
        longint h, p, num, den, v;
        h   = (longint'(1) << aw) / 2;
        p   = longint'(k) % h;
        num = 16 * p * (h - p);
        den = 5 * h * h - 4 * p * (h - p);
        v   = (longint'(amp) * num + den / 2) / den;
        return (longint'(k) >= h) ? -int'(v) : int'(v);
    endfunction

endpackage

// File: rtl/nco_inc_bank.sv
// Banked phase-step store: register port A (read/write), accumulator port B (read).
// Assumes software never writes the bank that port B is currently reading.
module nco_inc_bank #(
    parameter int NUM_CH    = 4,
    parameter int NUM_BANKS = 3,
    parameter int ACC_W     = 16,
    parameter int REG_AW    = 4,
    parameter int CH_W      = 2,
    parameter int BANK_W    = 2,
    localparam int INC_W    = ACC_W + 2,
    localparam int DEPTH    = NUM_BANKS * NUM_CH,
    localparam int IDX_W    = (DEPTH > 1) ? $clog2(DEPTH) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              reg_req,
    input  logic              reg_write,
    input  logic [REG_AW-1:0] reg_addr,
    input  logic [INC_W-1:0]  reg_wdata,
    output logic [INC_W-1:0]  reg_rdata,
    output logic              reg_rvalid,
    input  logic [BANK_W-1:0] rd_bank,
    input  logic [CH_W-1:0]   rd_ch,
    output logic [INC_W-1:0]  rd_inc
);

    logic [DEPTH-1:0][INC_W-1:0] mem;
    logic                        a_hit;
    logic [IDX_W-1:0]            a_idx;
    logic [IDX_W-1:0]            b_idx;

    // Decode the register address and the bank/channel fetch address.
    always_comb begin
        a_hit = int'(reg_addr) < DEPTH;
        a_idx = IDX_W'(reg_addr);
        b_idx = IDX_W'(int'(rd_bank) * NUM_CH + int'(rd_ch));
    end

    // Store register writes that land inside the map.
    always_ff @(posedge clk) begin
        if (!rst_n)
            mem <= '0;
        else if (reg_req && reg_write && a_hit)
            mem[a_idx] <= reg_wdata;
    end

    // Register-port read: one cycle of latency, zero outside the map.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            reg_rdata  <= '0;
            reg_rvalid <= 1'b0;
        end else begin
            reg_rvalid <= reg_req && !reg_write;
            if (reg_req && !reg_write)
                reg_rdata <= a_hit ? mem[a_idx] : '0;
        end
    end

    // Accumulator-port fetch of the active bank's step.
    always_ff @(posedge clk) begin
        if (!rst_n)
            rd_inc <= '0;
        else
            rd_inc <= mem[b_idx];
    end

    AST_RVALID_FROM_READ: assert property (@(posedge clk) disable iff (!rst_n)
        reg_rvalid |-> $past(reg_req && !reg_write)); // R2

    AST_STORE_ONLY_ON_WRITE: assert property (@(posedge clk) disable iff (!rst_n)
        !(reg_req && reg_write) |=> $stable(mem)); // R9

endmodule

// File: rtl/nco_phase_acc.sv
// Per-channel phase accumulators and offsets; produces the table index and inversion flags.
// Assumes at most one sample per cycle; same-channel samples may follow back to back.
module nco_phase_acc #(
    parameter int NUM_CH = 4,
    parameter int ACC_W  = 16,
    parameter int LUT_AW = 8,
    parameter int CH_W   = 2,
    localparam int INC_W = ACC_W + 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              in_valid,
    input  logic [CH_W-1:0]   in_ch,
    input  logic [INC_W-1:0]  in_inc,
    input  logic              in_sync,
    input  logic [ACC_W-1:0]  in_phase,
    output logic [LUT_AW-1:0] lut_idx,
    output logic              inv_sin,
    output logic              inv_cos
);

    logic [NUM_CH-1:0][ACC_W-1:0] acc;
    logic [NUM_CH-1:0][ACC_W-1:0] off;
    logic [ACC_W-1:0]             base;
    logic [ACC_W-1:0]             ofs;
    logic [ACC_W-1:0]             sum;

    // Pick the starting phase and offset, honouring a sync restart.
    always_comb begin
        base = in_sync ? '0 : acc[in_ch];
        ofs  = in_sync ? in_phase : off[in_ch];
        sum  = base + ofs;
    end

    // Advance the addressed channel only on a valid sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            acc <= '0;
            off <= '0;
        end else if (in_valid) begin
            acc[in_ch] <= base + in_inc[ACC_W-1:0];
            off[in_ch] <= ofs;
        end
    end

    // Register the table index and the inversion flags of this sample.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            lut_idx <= '0;
            inv_sin <= 1'b0;
            inv_cos <= 1'b0;
        end else begin
            lut_idx <= sum[ACC_W-1 -: LUT_AW];
            inv_sin <= in_inc[ACC_W];
            inv_cos <= in_inc[ACC_W+1];
        end
    end

    AST_IDLE_HOLDS_PHASE: assert property (@(posedge clk) disable iff (!rst_n)
        !in_valid |=> ($stable(acc) && $stable(off))); // R10

    AST_SYNC_RESTARTS: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && in_sync) |=> (acc[$past(in_ch)] == $past(in_inc[ACC_W-1:0]))); // R9

endmodule

// File: rtl/nco_sine_rom.sv
// Full-wave sine table computed at elaboration; two registered reads (sine, quarter-shifted cosine).
// Assumes LUT_AW >= 2 so that a quarter turn is a whole number of entries.
module nco_sine_rom
    import nco_pkg::*;
#(
    parameter int LUT_AW = 8,
    parameter int OUT_W  = 12,
    localparam int N     = 1 << LUT_AW,
    localparam int AMP   = (1 << (OUT_W - 1)) - 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic [LUT_AW-1:0]       idx,
    output logic signed [OUT_W-1:0] sin_raw,
    output logic signed [OUT_W-1:0] cos_raw
);

    logic signed [OUT_W-1:0] rom_q [N];
    logic [LUT_AW-1:0]       cos_idx;

    for (genvar k = 0; k < N; k++) begin : g_rom
        localparam logic signed [OUT_W-1:0] VAL = OUT_W'(sine_q(k, LUT_AW, AMP));
        assign rom_q[k] = VAL;
    end

    // Cosine is the sine a quarter turn ahead.
    always_comb cos_idx = idx + LUT_AW'(N / 4);

    // Registered table reads.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            sin_raw <= '0;
            cos_raw <= '0;
        end else begin
            sin_raw <= rom_q[idx];
            cos_raw <= rom_q[cos_idx];
        end
    end

endmodule

// File: rtl/nco_hop_top.sv
// Banked frequency-hopping oscillator top: clamps the bank, aligns tags with the 4-stage datapath.
// Assumes software writes only banks other than the one on in_bank.
module nco_hop_top
    import nco_pkg::*;
#(
    parameter int NUM_CH    = 4,
    parameter int NUM_BANKS = 3,
    parameter int ACC_W     = 16,
    parameter int LUT_AW    = 8,
    parameter int OUT_W     = 12,
    parameter int REG_AW    = 4,
    localparam int INC_W    = ACC_W + 2,
    localparam int CH_W     = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int BANK_W   = (NUM_BANKS > 1) ? $clog2(NUM_BANKS) : 1
) (
    input  logic                    clk,
    input  logic                    rst_n,
    input  logic                    in_valid,
    input  logic [CH_W-1:0]         in_ch,
    input  logic [BANK_W-1:0]       in_bank,
    input  logic                    in_sync,
    input  logic [ACC_W-1:0]        in_phase,
    input  logic                    reg_req,
    input  logic                    reg_write,
    input  logic [REG_AW-1:0]       reg_addr,
    input  logic [INC_W-1:0]        reg_wdata,
    output logic [INC_W-1:0]        reg_rdata,
    output logic                    reg_rvalid,
    output logic                    out_valid,
    output logic [CH_W-1:0]         out_ch,
    output logic [BANK_W-1:0]       out_bank,
    output logic signed [OUT_W-1:0] out_sin,
    output logic signed [OUT_W-1:0] out_cos
);

    logic [BANK_W-1:0]       bank_c;
    logic                    s1_valid, s1_sync;
    logic [CH_W-1:0]         s1_ch;
    logic [BANK_W-1:0]       s1_bank;
    logic [ACC_W-1:0]        s1_phase;
    logic [INC_W-1:0]        s1_inc;
    logic [LUT_AW-1:0]       lut_idx;
    logic                    inv2_sin, inv2_cos, inv3_sin, inv3_cos;
    logic                    t2_valid, t3_valid;
    logic [CH_W-1:0]         t2_ch, t3_ch;
    logic [BANK_W-1:0]       t2_bank, t3_bank;
    logic signed [OUT_W-1:0] sin_raw, cos_raw;
    logic [2:0]              lat_cnt;

    // Clamp an out-of-range bank index to the last bank.
    always_comb bank_c = (int'(in_bank) >= NUM_BANKS) ? BANK_W'(NUM_BANKS - 1) : in_bank;

    nco_inc_bank #(
        .NUM_CH(NUM_CH), .NUM_BANKS(NUM_BANKS), .ACC_W(ACC_W),
        .REG_AW(REG_AW), .CH_W(CH_W), .BANK_W(BANK_W)
    ) u_bank (
        .clk(clk), .rst_n(rst_n),
        .reg_req(reg_req), .reg_write(reg_write), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .reg_rvalid(reg_rvalid),
        .rd_bank(bank_c), .rd_ch(in_ch), .rd_inc(s1_inc)
    );

    // Stage 1: capture the sample alongside the step fetch.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s1_valid <= 1'b0; s1_sync <= 1'b0; s1_ch <= '0; s1_bank <= '0; s1_phase <= '0;
        end else begin
            s1_valid <= in_valid; s1_sync <= in_sync; s1_ch <= in_ch;
            s1_bank  <= bank_c;   s1_phase <= in_phase;
        end
    end

    nco_phase_acc #(
        .NUM_CH(NUM_CH), .ACC_W(ACC_W), .LUT_AW(LUT_AW), .CH_W(CH_W)
    ) u_acc (
        .clk(clk), .rst_n(rst_n),
        .in_valid(s1_valid), .in_ch(s1_ch), .in_inc(s1_inc),
        .in_sync(s1_sync), .in_phase(s1_phase),
        .lut_idx(lut_idx), .inv_sin(inv2_sin), .inv_cos(inv2_cos)
    );

    nco_sine_rom #(.LUT_AW(LUT_AW), .OUT_W(OUT_W)) u_rom (
        .clk(clk), .rst_n(rst_n), .idx(lut_idx), .sin_raw(sin_raw), .cos_raw(cos_raw)
    );

    // Stages 2-3: carry the tags and inversion flags beside the datapath.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            t2_valid <= 1'b0; t2_ch <= '0; t2_bank <= '0;
            t3_valid <= 1'b0; t3_ch <= '0; t3_bank <= '0;
            inv3_sin <= 1'b0; inv3_cos <= 1'b0;
        end else begin
            t2_valid <= s1_valid; t2_ch <= s1_ch; t2_bank <= s1_bank;
            t3_valid <= t2_valid; t3_ch <= t2_ch; t3_bank <= t2_bank;
            inv3_sin <= inv2_sin; inv3_cos <= inv2_cos;
        end
    end

    // Stage 4: apply inversions and register the outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            out_valid <= 1'b0; out_ch <= '0; out_bank <= '0; out_sin <= '0; out_cos <= '0;
        end else begin
            out_valid <= t3_valid; out_ch <= t3_ch; out_bank <= t3_bank;
            out_sin   <= inv3_sin ? -sin_raw : sin_raw;
            out_cos   <= inv3_cos ? -cos_raw : cos_raw;
        end
    end

    // Edges since reset, saturating at the pipeline depth (qualifies the latency checks).
    always_ff @(posedge clk) begin
        if (!rst_n)
            lat_cnt <= '0;
        else if (int'(lat_cnt) < NCO_LATENCY)
            lat_cnt <= lat_cnt + 3'd1;
    end

    AST_OUT_LATENCY: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt == 3'd4) |-> (out_valid == $past(in_valid, 4))); // R6

    AST_OUT_CH_TAG: assert property (@(posedge clk) disable iff (!rst_n)
        (lat_cnt == 3'd4 && out_valid) |-> (out_ch == $past(in_ch, 4))); // R6

    AST_BANK_IN_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (int'(out_bank) < NUM_BANKS)); // R8

endmodule

// File: tb/test_nco_hop_top.sv
// Scoreboard bench: the driver predicts each sample from a phase model, the monitor compares.
module test_nco_hop_top;

    localparam int NCH = 4, NB = 3, TOL = 5, AMP = 2047;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        in_valid = 1'b0, in_sync = 1'b0;
    logic [1:0]  in_ch = '0, in_bank = '0;
    logic [15:0] in_phase = '0;
    logic        reg_req = 1'b0, reg_write = 1'b0;
    logic [3:0]  reg_addr = '0;
    logic [17:0] reg_wdata = '0;
    logic [17:0] reg_rdata;
    logic        reg_rvalid, out_valid;
    logic [1:0]  out_ch, out_bank;
    logic signed [11:0] out_sin, out_cos;

    nco_hop_top i_nco_hop_top (
        .clk(clk), .rst_n(rst_n), .in_valid(in_valid), .in_ch(in_ch), .in_bank(in_bank),
        .in_sync(in_sync), .in_phase(in_phase), .reg_req(reg_req), .reg_write(reg_write),
        .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata),
        .reg_rvalid(reg_rvalid), .out_valid(out_valid), .out_ch(out_ch), .out_bank(out_bank),
        .out_sin(out_sin), .out_cos(out_cos)
    );

    always #5 clk = ~clk;

    typedef struct {
        int    ch;
        int    bank;
        int    s;
        int    c;
        int    cyc;
        string req;
    } exp_t;

    exp_t  q[$];
    int    checks = 0, failures = 0, cyc = 0;
    int    mem_m [NB*NCH];
    int    acc_m [NCH];
    int    off_m [NCH];
    bit    done = 1'b0;

    always @(posedge clk) cyc <= cyc + 1;

    function automatic int ref_sin(input int k);
        real r;
        r = AMP * $sin(2.0 * 3.14159265358979 * k / 256.0);
        return int'(r);
    endfunction

    function automatic int absd(input int a, input int b);
        return (a > b) ? a - b : b - a;
    endfunction

    task automatic check(input bit ok, input string req, input string what, input int act, input int exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    task automatic reg_wr(input int addr, input int data);
        @(negedge clk);
        in_valid = 1'b0;
        reg_req = 1'b1; reg_write = 1'b1; reg_addr = 4'(addr); reg_wdata = 18'(data);
        if (addr < NB*NCH) mem_m[addr] = data & 18'h3FFFF;
        @(negedge clk);
        reg_req = 1'b0; reg_write = 1'b0;
    endtask

    task automatic reg_rd(input int addr, input int exp, input string req);
        @(negedge clk);
        in_valid = 1'b0;
        reg_req = 1'b1; reg_write = 1'b0; reg_addr = 4'(addr);
        @(negedge clk);
        reg_req = 1'b0;
        check(reg_rvalid === 1'b1, req, "reg_rvalid", int'(reg_rvalid), 1);
        check(int'(reg_rdata) == exp, req, "reg_rdata", int'(reg_rdata), exp);
    endtask

    // Drive one sample and push its predicted result.
    task automatic send(input int ch, input int bank, input bit sync, input int phase, input string req);
        exp_t e;
        int bc, inc, base, ofs, idx;
        @(negedge clk);
        in_valid = 1'b1; in_ch = 2'(ch); in_bank = 2'(bank); in_sync = sync; in_phase = 16'(phase);
        bc   = (bank >= NB) ? NB - 1 : bank;
        inc  = mem_m[bc*NCH + ch];
        base = sync ? 0 : acc_m[ch];
        ofs  = sync ? (phase & 16'hFFFF) : off_m[ch];
        idx  = ((base + ofs) & 16'hFFFF) >> 8;
        acc_m[ch] = (base + (inc & 16'hFFFF)) & 16'hFFFF;
        off_m[ch] = ofs;
        e.ch = ch; e.bank = bc; e.cyc = cyc; e.req = req;
        e.s = ref_sin(idx);
        e.c = ref_sin((idx + 64) % 256);
        if (inc[16]) e.s = -e.s;
        if (inc[17]) e.c = -e.c;
        q.push_back(e);
    endtask

    task automatic quiet(input int n);
        @(negedge clk);
        in_valid = 1'b0; in_sync = 1'b0;
        repeat (n - 1) @(negedge clk);
    endtask

    // Monitor: pop and compare every output sample.
    always @(negedge clk) begin
        if (rst_n && out_valid) begin
            if (q.size() == 0) begin
                check(1'b0, "R6", "unexpected out_valid", 1, 0);
            end else begin
                exp_t e;
                e = q.pop_front();
                check(cyc - e.cyc == 4, "R6", "latency", cyc - e.cyc, 4);
                check(int'(out_ch) == e.ch, "R6", "out_ch", int'(out_ch), e.ch);
                check(int'(out_bank) == e.bank, {e.req, "/R8"}, "out_bank", int'(out_bank), e.bank);
                check(absd(int'(out_sin), e.s) <= TOL, {e.req, "/R4"}, "out_sin", int'(out_sin), e.s);
                check(absd(int'(out_cos), e.c) <= TOL, {e.req, "/R4"}, "out_cos", int'(out_cos), e.c);
            end
        end
    end

    // Watchdog: an overlong run is counted as a failure.
    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            failures++;
            $display("FAIL R6 watchdog: actual=timeout expected=completion");
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    initial begin
        for (int i = 0; i < NB*NCH; i++) mem_m[i] = 0;
        for (int i = 0; i < NCH; i++) begin acc_m[i] = 0; off_m[i] = 0; end
        in_valid = 1'b1;
        repeat (5) @(negedge clk);
        // R1: outputs quiet while reset is held, even with in_valid high
        check(out_valid === 1'b0, "R1", "out_valid in reset", int'(out_valid), 0);
        check(reg_rvalid === 1'b0, "R1", "reg_rvalid in reset", int'(reg_rvalid), 0);
        in_valid = 1'b0;
        rst_n = 1'b1;
        @(negedge clk);
        check(out_valid === 1'b0, "R1", "out_valid after reset", int'(out_valid), 0);
        reg_rd(5, 0, "R1");

        // R2: bank-major address map, read-back, out-of-map addresses
        reg_wr(0, 16'h0100); reg_wr(1, 16'h0333); reg_wr(2, 16'h1000); reg_wr(3, 16'h00C0);
        reg_wr(4, 16'h0800); reg_wr(5, 16'h0050); reg_wr(6, 16'h2222); reg_wr(7, 16'h0400);
        reg_wr(8,  (1 << 16) | 16'h0280);
        reg_wr(9,  (1 << 17) | 16'h0700);
        reg_wr(10, (3 << 16) | 16'h0A00);
        reg_wr(11, 16'h0123);
        reg_rd(0, 16'h0100, "R2");
        reg_rd(6, 16'h2222, "R2");
        reg_rd(10, (3 << 16) | 16'h0A00, "R2");
        reg_wr(12, 18'h3FFFF);
        reg_rd(12, 0, "R2");
        reg_rd(0, 16'h0100, "R2");
        reg_rd(13, 0, "R2");

        // R3: one channel, back-to-back samples
        for (int i = 0; i < 10; i++) send(0, 0, 1'b0, 0, "R3");
        // R11: channels interleaved
        for (int i = 0; i < 3; i++)
            for (int c = 0; c < NCH; c++) send(c, 0, 1'b0, 0, "R11");
        // R10: idle gaps leave the phase untouched
        send(1, 0, 1'b0, 0, "R10");
        quiet(3);
        send(1, 0, 1'b0, 0, "R10");
        quiet(2);
        send(1, 0, 1'b0, 0, "R10");
        // R7: hop to bank 1 and back, phase continuous
        for (int i = 0; i < 6; i++) send(0, 1, 1'b0, 0, "R7");
        for (int i = 0; i < 4; i++) send(0, 0, 1'b0, 0, "R7");
        for (int i = 0; i < 4; i++) send(2, 1, 1'b0, 0, "R7");
        // R5: inversion flags in bank 2
        for (int i = 0; i < 3; i++)
            for (int c = 0; c < 3; c++) send(c, 2, 1'b0, 0, "R5");
        // R8: bank index 3 clamps to bank 2
        for (int i = 0; i < 4; i++) send(3, 3, 1'b0, 0, "R8");
        send(0, 3, 1'b0, 0, "R8");
        // R9: sync restarts one channel from the given offset
        send(2, 0, 1'b1, 16'h4000, "R9");
        for (int i = 0; i < 4; i++) send(2, 0, 1'b0, 0, "R9");
        send(3, 1, 1'b1, 16'hC100, "R9");
        send(3, 1, 1'b0, 0, "R9");
        quiet(8);
        reg_rd(2, 16'h1000, "R9");
        reg_rd(7, 16'h0400, "R9");

        quiet(4);
        check(q.size() == 0, "R6", "outstanding samples", q.size(), 0);
        done = 1'b1;
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule